// File: doc/BRIEF.md
# Cross-Side Flag and Interrupt Signaler

This block carries small, low-latency signals between two processor sides, called side A and side B. Each side owns a short flag field. A value written there reaches the other side through a fixed synchronizing delay. While the value is in transit, the writing side sees a busy bit, and it cannot change the flags until the transfer completes.

Each side can also raise four general-purpose interrupt requests and one non-maskable interrupt toward the other side. A trigger that is accepted sets a request bit on the sender and a pending bit on the receiver. Both stay set until the receiver clears the pending bit by writing one to it. A new trigger on a channel whose earlier request is still outstanding is refused, and the sender sees a failure indication.

When one side starts a messaging-unit reset, the other side can record the event in general-purpose channel 3 if its reset-notification enable is set. Each side has a maskable interrupt output, formed from its pending bits and enables, and a separate non-maskable output.

Top module: `xside_signaler`

## Requirements
- R1: A flag write accepted on one side appears on the other side's peer-flag output exactly 2 clock edges after the edge that accepts it. Whenever the writing side is not busy, its peer-flag output on the far side equals its own flag value.
- R2: Every accepted flag write raises that side's busy output at the accepting edge. Busy stays high for 2 cycles and falls at the edge where the new value becomes visible.
- R3: A flag write presented while that side's busy output is high is ignored: neither the own value nor the value later seen by the peer changes.
- R4: A general-purpose trigger bit on a channel with no outstanding request sets, at the next edge, the sender's request bit and the receiver's pending bit at the same bit index. Bit i is channel i.
- R5: When a trigger bit is presented on a channel whose request bit is already set, the sender's fail output is high in that same cycle, and the request and pending state of that channel do not change.
- R6: A receiver pending bit is cleared only by a write-one-to-clear on that side's clear input. The same edge clears the sender's matching request bit. A clear bit on a channel that is not pending has no effect.
- R7: Each side's irq output is high exactly when some pending bit has its matching enable bit set.
- R8: A non-maskable trigger sets the receiver's nmi output at the next edge, regardless of the enables. It stays set until the receiver pulses its nmi-clear input.
- R9: A reset-start pulse from one side sets pending bit 3 on the other side only if that side's reset-notification enable is high. It does not set the sender's request bit 3. With the enable low, the pulse has no effect.
- R10: After reset, all flags, busy, request, pending, fail, irq and nmi outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_flag_wr_i | input | 1 | Side A flag write strobe |
| a_flag_wdata_i | input | FLAG_W | Side A new flag value |
| a_flag_own_o | output | FLAG_W | Side A flag value as held by side A |
| a_flag_peer_o | output | FLAG_W | Side B flag value as seen by side A |
| a_flag_busy_o | output | 1 | Side A flag transfer in flight |
| a_gp_trig_i | input | NUM_GP | Side A general-purpose trigger, one bit per channel |
| a_gp_fail_o | output | 1 | Side A trigger hit an outstanding request |
| a_gp_req_o | output | NUM_GP | Side A outstanding requests toward side B |
| a_nmi_trig_i | input | 1 | Side A non-maskable trigger toward side B |
| a_nmi_req_o | output | 1 | Side A outstanding non-maskable request |
| a_gp_clr_i | input | NUM_GP | Side A write-one-to-clear of its pending bits |
| a_gp_ien_i | input | NUM_GP | Side A interrupt enables |
| a_gp_pend_o | output | NUM_GP | Side A pending bits, raised by side B |
| a_nmi_clr_i | input | 1 | Side A clear of a received non-maskable interrupt |
| a_murst_start_i | input | 1 | Side A starts a messaging-unit reset |
| a_murst_ien_i | input | 1 | Side A enable for the reset notification from side B |
| a_irq_o | output | 1 | Side A maskable interrupt |
| a_nmi_o | output | 1 | Side A non-maskable interrupt |
| b_flag_wr_i | input | 1 | Side B flag write strobe |
| b_flag_wdata_i | input | FLAG_W | Side B new flag value |
| b_flag_own_o | output | FLAG_W | Side B flag value as held by side B |
| b_flag_peer_o | output | FLAG_W | Side A flag value as seen by side B |
| b_flag_busy_o | output | 1 | Side B flag transfer in flight |
| b_gp_trig_i | input | NUM_GP | Side B general-purpose trigger |
| b_gp_fail_o | output | 1 | Side B trigger hit an outstanding request |
| b_gp_req_o | output | NUM_GP | Side B outstanding requests toward side A |
| b_nmi_trig_i | input | 1 | Side B non-maskable trigger toward side A |
| b_nmi_req_o | output | 1 | Side B outstanding non-maskable request |
| b_gp_clr_i | input | NUM_GP | Side B write-one-to-clear of its pending bits |
| b_gp_ien_i | input | NUM_GP | Side B interrupt enables |
| b_gp_pend_o | output | NUM_GP | Side B pending bits, raised by side A |
| b_nmi_clr_i | input | 1 | Side B clear of a received non-maskable interrupt |
| b_murst_start_i | input | 1 | Side B starts a messaging-unit reset |
| b_murst_ien_i | input | 1 | Side B enable for the reset notification from side A |
| b_irq_o | output | 1 | Side B maskable interrupt |
| b_nmi_o | output | 1 | Side B non-maskable interrupt |

## Verification
The bench checks the peer flag one cycle before and at the exact edge it should change. A design with the wrong synchronizer depth, or with busy falling early or late, shows the new value too soon or busy in the wrong cycle. It writes a second flag value while busy is high: a design that fails to block that write shows the second value on the peer side.

The interrupt sequences cover several cases. A re-trigger on an outstanding channel must raise fail and leave the state unchanged, which catches a design that overwrites or drops the request. A clear of a channel that is not pending must do nothing. A trigger on one channel and a clear on another arrive in the same cycle. The reset notification must set bit 3 only when enabled and must not set the sender's request, which catches a design with a missing enable or one that wires the notification to the wrong channel.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int FLAG_W      = 3;
  localparam int NUM_GP      = 4;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/xs_flag_link.sv
// One direction of flag transfer: owner register, sync pipe, busy window.
module xs_flag_link #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] own_o,
  output logic         busy_o,
  output logic [W-1:0] peer_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0]      own_q;
  logic [W-1:0]      pipe_q [STAGES];
  logic [STAGES-1:0] tok_q;
  logic              busy_q;
  logic              accept;

  assign accept = wr_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= '0;
      tok_q  <= '0;
      busy_q <= 1'b0;
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      if (accept) own_q <= wdata_i;
      tok_q     <= {tok_q[STAGES-2:0], accept};
      busy_q    <= accept | (busy_q & ~tok_q[LAST]);
      pipe_q[0] <= own_q;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign own_o  = own_q;
  assign busy_o = busy_q;
  assign peer_o = pipe_q[LAST];
endmodule

// File: rtl/xs_irq_link.sv
// One direction of interrupt signalling: sender requests, receiver pending.
module xs_irq_link #(
  parameter int NUM_GP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_GP-1:0] gp_trig_i,
  input  logic              nmi_trig_i,
  output logic [NUM_GP-1:0] gp_req_o,
  output logic              nmi_req_o,
  output logic              gp_fail_o,
  input  logic [NUM_GP-1:0] gp_clr_i,
  input  logic [NUM_GP-1:0] gp_ien_i,
  input  logic              nmi_clr_i,
  input  logic              murst_set_i,
  output logic [NUM_GP-1:0] gp_pend_o,
  output logic              irq_o,
  output logic              nmi_o
);
  localparam int MURST_CH = NUM_GP - 1;

  logic [NUM_GP-1:0] req_q, pend_q;
  logic              nreq_q, npend_q;
  logic              nacc;

  for (genvar i = 0; i < NUM_GP; i++) begin : g_ch
    logic acc, hit, set;
    assign acc = gp_trig_i[i] & ~req_q[i];
    assign hit = gp_clr_i[i] & pend_q[i];
    assign set = acc | ((i == MURST_CH) ? murst_set_i : 1'b0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (acc)      req_q[i] <= 1'b1;
        else if (hit) req_q[i] <= 1'b0;
        if (set)      pend_q[i] <= 1'b1;
        else if (hit) pend_q[i] <= 1'b0;
      end
    end
  end

  assign nacc = nmi_trig_i & ~nreq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nreq_q  <= 1'b0;
      npend_q <= 1'b0;
    end else begin
      if (nacc)                     nreq_q <= 1'b1;
      else if (nmi_clr_i & npend_q) nreq_q <= 1'b0;
      if (nacc)                     npend_q <= 1'b1;
      else if (nmi_clr_i)           npend_q <= 1'b0;
    end
  end

  assign gp_req_o  = req_q;
  assign nmi_req_o = nreq_q;
  assign gp_fail_o = |(gp_trig_i & req_q);
  assign gp_pend_o = pend_q;
  assign irq_o     = |(pend_q & gp_ien_i);
  assign nmi_o     = npend_q;
endmodule

// File: rtl/xside_signaler.sv
module xside_signaler
  import xs_pkg::*;
#(
  parameter int FW  = FLAG_W,
  parameter int NGP = NUM_GP,
  parameter int NSY = SYNC_STAGES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a_flag_wr_i,
  input  logic [FW-1:0]  a_flag_wdata_i,
  output logic [FW-1:0]  a_flag_own_o,
  output logic [FW-1:0]  a_flag_peer_o,
  output logic           a_flag_busy_o,
  input  logic [NGP-1:0] a_gp_trig_i,
  output logic           a_gp_fail_o,
  output logic [NGP-1:0] a_gp_req_o,
  input  logic           a_nmi_trig_i,
  output logic           a_nmi_req_o,
  input  logic [NGP-1:0] a_gp_clr_i,
  input  logic [NGP-1:0] a_gp_ien_i,
  output logic [NGP-1:0] a_gp_pend_o,
  input  logic           a_nmi_clr_i,
  input  logic           a_murst_start_i,
  input  logic           a_murst_ien_i,
  output logic           a_irq_o,
  output logic           a_nmi_o,
  input  logic           b_flag_wr_i,
  input  logic [FW-1:0]  b_flag_wdata_i,
  output logic [FW-1:0]  b_flag_own_o,
  output logic [FW-1:0]  b_flag_peer_o,
  output logic           b_flag_busy_o,
  input  logic [NGP-1:0] b_gp_trig_i,
  output logic           b_gp_fail_o,
  output logic [NGP-1:0] b_gp_req_o,
  input  logic           b_nmi_trig_i,
  output logic           b_nmi_req_o,
  input  logic [NGP-1:0] b_gp_clr_i,
  input  logic [NGP-1:0] b_gp_ien_i,
  output logic [NGP-1:0] b_gp_pend_o,
  input  logic           b_nmi_clr_i,
  input  logic           b_murst_start_i,
  input  logic           b_murst_ien_i,
  output logic           b_irq_o,
  output logic           b_nmi_o
);
  xs_flag_link #(.W(FW), .STAGES(NSY)) u_flag_a2b (
    .clk_i, .rst_ni,
    .wr_i(a_flag_wr_i), .wdata_i(a_flag_wdata_i),
    .own_o(a_flag_own_o), .busy_o(a_flag_busy_o), .peer_o(b_flag_peer_o)
  );

  xs_flag_link #(.W(FW), .STAGES(NSY)) u_flag_b2a (
    .clk_i, .rst_ni,
    .wr_i(b_flag_wr_i), .wdata_i(b_flag_wdata_i),
    .own_o(b_flag_own_o), .busy_o(b_flag_busy_o), .peer_o(a_flag_peer_o)
  );

  // reset notification is gated by the receiving side's enable
  xs_irq_link #(.NUM_GP(NGP)) u_irq_a2b (
    .clk_i, .rst_ni,
    .gp_trig_i(a_gp_trig_i), .nmi_trig_i(a_nmi_trig_i),
    .gp_req_o(a_gp_req_o), .nmi_req_o(a_nmi_req_o), .gp_fail_o(a_gp_fail_o),
    .gp_clr_i(b_gp_clr_i), .gp_ien_i(b_gp_ien_i), .nmi_clr_i(b_nmi_clr_i),
    .murst_set_i(a_murst_start_i & b_murst_ien_i),
    .gp_pend_o(b_gp_pend_o), .irq_o(b_irq_o), .nmi_o(b_nmi_o)
  );

  xs_irq_link #(.NUM_GP(NGP)) u_irq_b2a (
    .clk_i, .rst_ni,
    .gp_trig_i(b_gp_trig_i), .nmi_trig_i(b_nmi_trig_i),
    .gp_req_o(b_gp_req_o), .nmi_req_o(b_nmi_req_o), .gp_fail_o(b_gp_fail_o),
    .gp_clr_i(a_gp_clr_i), .gp_ien_i(a_gp_ien_i), .nmi_clr_i(a_nmi_clr_i),
    .murst_set_i(b_murst_start_i & a_murst_ien_i),
    .gp_pend_o(a_gp_pend_o), .irq_o(a_irq_o), .nmi_o(a_nmi_o)
  );
endmodule

// File: rtl/xs_signaler_chk.sv
module xs_signaler_chk #(
  parameter int FW  = 3,
  parameter int NGP = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           a_flag_wr_i,
  input logic [FW-1:0]  a_flag_own_o,
  input logic           a_flag_busy_o,
  input logic [FW-1:0]  b_flag_peer_o,
  input logic [NGP-1:0] a_gp_trig_i,
  input logic [NGP-1:0] a_gp_req_o,
  input logic           a_gp_fail_o,
  input logic [NGP-1:0] b_gp_pend_o,
  input logic [NGP-1:0] b_gp_clr_i,
  input logic           a_nmi_trig_i,
  input logic           b_nmi_clr_i,
  input logic           b_nmi_o
);
  p_peer_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_flag_busy_o |-> (b_flag_peer_o == a_flag_own_o));

  p_busy_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a_flag_busy_o) |=> a_flag_busy_o);

  p_busy_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_flag_busy_o && a_flag_wr_i) |=> $stable(a_flag_own_o));

  p_req_has_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_gp_req_o & ~b_gp_pend_o) == '0);

  p_retrig_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_gp_trig_i & a_gp_req_o) != '0) |-> a_gp_fail_o);

  p_pend_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((b_gp_pend_o & ~b_gp_clr_i) != '0) |=>
      (($past(b_gp_pend_o & ~b_gp_clr_i) & ~b_gp_pend_o) == '0));

  p_nmi_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_nmi_clr_i && !a_nmi_trig_i) |=> !b_nmi_o);
endmodule

bind xside_signaler xs_signaler_chk #(.FW(FW), .NGP(NGP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .a_flag_wr_i(a_flag_wr_i), .a_flag_own_o(a_flag_own_o),
  .a_flag_busy_o(a_flag_busy_o), .b_flag_peer_o(b_flag_peer_o),
  .a_gp_trig_i(a_gp_trig_i), .a_gp_req_o(a_gp_req_o), .a_gp_fail_o(a_gp_fail_o),
  .b_gp_pend_o(b_gp_pend_o), .b_gp_clr_i(b_gp_clr_i),
  .a_nmi_trig_i(a_nmi_trig_i), .b_nmi_clr_i(b_nmi_clr_i), .b_nmi_o(b_nmi_o)
);

// File: tb/tb_xside_signaler.sv
module tb_xside_signaler;
  localparam int FW  = 3;
  localparam int NGP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           a_flag_wr = 0, b_flag_wr = 0;
  logic [FW-1:0]  a_flag_wdata = 0, b_flag_wdata = 0;
  logic [FW-1:0]  a_flag_own, a_flag_peer, b_flag_own, b_flag_peer;
  logic           a_flag_busy, b_flag_busy;
  logic [NGP-1:0] a_gp_trig = 0, b_gp_trig = 0, a_gp_clr = 0, b_gp_clr = 0;
  logic [NGP-1:0] a_gp_ien = 0, b_gp_ien = 0;
  logic [NGP-1:0] a_gp_req, b_gp_req, a_gp_pend, b_gp_pend;
  logic           a_gp_fail, b_gp_fail, a_nmi_req, b_nmi_req;
  logic           a_nmi_trig = 0, b_nmi_trig = 0, a_nmi_clr = 0, b_nmi_clr = 0;
  logic           a_murst = 0, b_murst = 0, a_murst_ien = 0, b_murst_ien = 0;
  logic           a_irq, b_irq, a_nmi, b_nmi;

  xside_signaler dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_flag_wr_i(a_flag_wr), .a_flag_wdata_i(a_flag_wdata),
    .a_flag_own_o(a_flag_own), .a_flag_peer_o(a_flag_peer), .a_flag_busy_o(a_flag_busy),
    .a_gp_trig_i(a_gp_trig), .a_gp_fail_o(a_gp_fail), .a_gp_req_o(a_gp_req),
    .a_nmi_trig_i(a_nmi_trig), .a_nmi_req_o(a_nmi_req),
    .a_gp_clr_i(a_gp_clr), .a_gp_ien_i(a_gp_ien), .a_gp_pend_o(a_gp_pend),
    .a_nmi_clr_i(a_nmi_clr), .a_murst_start_i(a_murst), .a_murst_ien_i(a_murst_ien),
    .a_irq_o(a_irq), .a_nmi_o(a_nmi),
    .b_flag_wr_i(b_flag_wr), .b_flag_wdata_i(b_flag_wdata),
    .b_flag_own_o(b_flag_own), .b_flag_peer_o(b_flag_peer), .b_flag_busy_o(b_flag_busy),
    .b_gp_trig_i(b_gp_trig), .b_gp_fail_o(b_gp_fail), .b_gp_req_o(b_gp_req),
    .b_nmi_trig_i(b_nmi_trig), .b_nmi_req_o(b_nmi_req),
    .b_gp_clr_i(b_gp_clr), .b_gp_ien_i(b_gp_ien), .b_gp_pend_o(b_gp_pend),
    .b_nmi_clr_i(b_nmi_clr), .b_murst_start_i(b_murst), .b_murst_ien_i(b_murst_ien),
    .b_irq_o(b_irq), .b_nmi_o(b_nmi)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {trig_a[21:18], clr_b[17:14], ien_b[13:10], req_a[9:6], pend_b[5:2], fail_a[1], irq_b[0]}
  localparam logic [21:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b0, 1'b0},
    {4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0001, 1'b1, 1'b1},
    {4'b0100, 4'b0001, 4'b0001, 4'b0100, 4'b0100, 1'b0, 1'b0},
    {4'b0000, 4'b0010, 4'b0100, 4'b0100, 4'b0100, 1'b0, 1'b1},
    {4'b1010, 4'b0100, 4'b1111, 4'b1010, 4'b1010, 1'b0, 1'b1},
    {4'b0000, 4'b1010, 4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0},
    {4'b1000, 4'b0000, 4'b0111, 4'b1000, 4'b1000, 1'b0, 1'b0},
    {4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 flags", {a_flag_own, a_flag_peer, b_flag_own, b_flag_peer}, 0);
    check("R10 busy", {a_flag_busy, b_flag_busy}, 0);
    check("R10 req/pend", {a_gp_req, b_gp_req, a_gp_pend, b_gp_pend}, 0);
    check("R10 irq/nmi/fail", {a_irq, b_irq, a_nmi, b_nmi, a_gp_fail, b_gp_fail}, 0);

    // table walk: A -> B general-purpose channels (R4 R5 R6 R7)
    for (int k = 0; k < 8; k++) begin
      a_gp_trig = VEC[k][21:18];
      b_gp_clr  = VEC[k][17:14];
      b_gp_ien  = VEC[k][13:10];
      #1;
      check($sformatf("R5 fail vec%0d", k), a_gp_fail, VEC[k][1]);
      @(posedge clk);
      #1;
      a_gp_trig = 0;
      b_gp_clr  = 0;
      check($sformatf("R4 req vec%0d", k), a_gp_req, VEC[k][9:6]);
      check($sformatf("R6 pend vec%0d", k), b_gp_pend, VEC[k][5:2]);
      check($sformatf("R7 irq vec%0d", k), b_irq, VEC[k][0]);
      @(negedge clk);
    end

    // R1 R2 R3: A flags to B, with a blocked write in the busy window
    a_flag_wr = 1; a_flag_wdata = 3'd5;
    tick();
    a_flag_wr = 0;
    check("R2 busy after write", a_flag_busy, 1);
    check("R1 peer not yet", b_flag_peer, 0);
    a_flag_wr = 1; a_flag_wdata = 3'd2;
    tick();
    a_flag_wr = 0;
    check("R2 busy second cycle", a_flag_busy, 1);
    check("R1 peer still old", b_flag_peer, 0);
    tick();
    check("R2 busy cleared", a_flag_busy, 0);
    check("R1 peer updated", b_flag_peer, 5);
    check("R3 own kept", a_flag_own, 5);
    repeat (3) tick();
    check("R3 peer kept", b_flag_peer, 5);

    // R1 B flags to A
    b_flag_wr = 1; b_flag_wdata = 3'd6;
    tick();
    b_flag_wr = 0;
    tick();
    check("R1 b2a early", a_flag_peer, 0);
    tick();
    check("R1 b2a arrived", a_flag_peer, 6);

    // R8 NMI A -> B, ignores enables
    b_gp_ien = 0;
    a_nmi_trig = 1;
    tick();
    a_nmi_trig = 0;
    check("R8 nmi set", b_nmi, 1);
    check("R7 irq not from nmi", b_irq, 0);
    repeat (2) tick();
    check("R8 nmi held", b_nmi, 1);
    b_nmi_clr = 1;
    tick();
    b_nmi_clr = 0;
    check("R8 nmi cleared", b_nmi, 0);

    // R9 reset notification
    b_gp_ien = 4'b1000;
    a_murst = 1; b_murst_ien = 0;
    tick();
    a_murst = 0;
    check("R9 disabled pend", b_gp_pend, 0);
    check("R9 disabled irq", b_irq, 0);
    a_murst = 1; b_murst_ien = 1;
    tick();
    a_murst = 0;
    check("R9 enabled pend", b_gp_pend, 4'b1000);
    check("R9 enabled irq", b_irq, 1);
    check("R9 no sender req", a_gp_req, 0);
    b_gp_clr = 4'b1000;
    tick();
    b_gp_clr = 0;
    check("R9 cleared", b_gp_pend, 0);

    // R4 R6 B -> A channel
    b_gp_trig = 4'b0010; a_gp_ien = 4'b0010;
    tick();
    b_gp_trig = 0;
    check("R4 b2a pend", a_gp_pend, 4'b0010);
    check("R4 b2a req", b_gp_req, 4'b0010);
    check("R7 a irq", a_irq, 1);
    a_gp_clr = 4'b0010;
    tick();
    a_gp_clr = 0;
    check("R6 b2a pend clr", a_gp_pend, 0);
    check("R6 b2a req clr", b_gp_req, 0);

    finish_run();
  end
endmodule